// File: doc/BRIEF.md
# Multi-master I2C mode and status controller

This block holds the mode and status byte of a multi-master I2C port. It watches single-cycle event strobes from the bit-level engine: START seen, STOP seen, byte finished, bit sampled, address match and general-call match. From these it keeps the master/slave and transmit/receive mode bits, the bus-busy, arbitration-lost, address-match, general-call and last-bit flags, and an active-low interrupt-request flag. The CPU reads the whole byte at any time. It writes the mode bits, and it writes a 1 to release the interrupt request.

The block also decides whether the engine may begin a START. A START request made while another master holds the bus is refused. The refusal suppresses START generation, the bit-counter reset and SCL drive in the same cycle, and it drops the master bit on the next edge. The master bit also falls at the end of a byte during which arbitration was lost, and on every detected STOP. When a hardware clear and a CPU write land in the same cycle, the hardware clear wins.

Top module: `i2c_mode_status_ctl`

## Requirements
- R1: After reset the status byte reads 0x10: mode bits, bus busy and all flags are 0, the interrupt-request bit is 1, and the gating outputs are 0.
- R2: A CPU write loads bit 7 (master) and bit 6 (transmit) on the next edge. The pair {bit7,bit6} reads back as the mode: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit.
- R3: A byte-end strobe while the arbitration-lost flag is set clears the master bit on the next edge.
- R4: A STOP strobe clears the master bit on the next edge, even when a CPU write sets it in that same cycle.
- R5: A START request while bus busy (bit 5) is 1 and the bus was not taken by this block holds start-enable, bit-counter-reset enable and SCL-drive enable at 0 in that cycle, and it clears the master bit on the next edge.
- R6: A START request while the master bit is 1 and the bus is free raises start-enable and bit-counter-reset enable in the same cycle. SCL-drive enable follows the master bit unless a request is refused.
- R7: The interrupt-request bit (bit 4) falls to 0 on the edge after a byte-end strobe. A CPU write with bit 4 at 1 sets it back to 1, and a write with bit 4 at 0 leaves it unchanged. A byte end in the same cycle as a release write wins.
- R8: Bus busy (bit 5) sets on a START strobe and clears on a STOP strobe. STOP wins when both arrive in the same cycle.
- R9: Arbitration lost (bit 3) sets when, with the master bit at 1, a bit-sample strobe sees SDA low while the block drives it high. It never sets while the master bit is 0, and a START strobe clears it.
- R10: The last-bit flag (bit 0) takes the SDA level at each bit-sample strobe. Address match (bit 2) and general call (bit 1) set on their strobes and clear on a START or STOP strobe.
- R11: CPU writes have no effect on bits 0 to 3 or bit 5.
- R12: The transmit bit is loaded by a write even in a cycle in which a hardware event clears the master bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe for the status byte |
| cpu_wdata | input | REG_W | CPU write data |
| cpu_rdata | output | REG_W | Status byte read value |
| ev_start_det | input | 1 | START condition detected on the bus |
| ev_stop_det | input | 1 | STOP condition detected on the bus |
| ev_byte_done | input | 1 | Byte transfer finished, acknowledge clock included |
| ev_bit_smp | input | 1 | SDA sampled for the current bit |
| sda_drive_hi | input | 1 | Block releases SDA high for the current bit |
| sda_in | input | 1 | Sampled SDA level |
| ev_addr_match | input | 1 | Slave address matched |
| ev_gc_match | input | 1 | General-call address matched |
| start_req | input | 1 | Engine asks to generate a START |
| start_gen_en | output | 1 | START generation permitted |
| bitcnt_rst_en | output | 1 | Bit-counter reset permitted |
| scl_drive_en | output | 1 | SCL clock drive permitted |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with the default REG_W of 8, which is the width of the packed status structure. At that width every flag and the mode pair can be checked against exact byte values. Its sequence covers an arbitration loss and byte end that drop the master bit, and a START from another master followed by a refused local START. It also covers same-cycle collisions: a write against a STOP, a release write against a byte end, and START against STOP.

// File: rtl/i2c_ms_pkg.sv
package i2c_ms_pkg;

  localparam int POS_LRB = 0;
  localparam int POS_GC  = 1;
  localparam int POS_AAS = 2;
  localparam int POS_AL  = 3;
  localparam int POS_IRQ = 4;
  localparam int POS_BB  = 5;
  localparam int POS_TRX = 6;
  localparam int POS_MST = 7;

  typedef struct packed {
    logic mst;
    logic trx;
    logic bb;
    logic irq_n;
    logic al;
    logic aas;
    logic gc;
    logic lrb;
  } ims_status_t;

  localparam int STATUS_W = $bits(ims_status_t);

  // Arbitration is lost when we release SDA high but the wire reads low.
  function automatic logic arb_lost_hit(input logic is_master, input logic smp,
                                        input logic drive_hi, input logic sda);
    return is_master & smp & drive_hi & ~sda;
  endfunction

  // Any hardware reason for the master bit to fall.
  function automatic logic master_drop(input logic stop, input logic byte_end,
                                       input logic al_now, input logic refused);
    return stop | (byte_end & al_now) | refused;
  endfunction

endpackage

// File: rtl/ims_start_guard.sv
module ims_start_guard (
  input  logic start_req,
  input  logic mst_q,
  input  logic bb_q,
  input  logic own_q,
  output logic refused,
  output logic start_gen_en,
  output logic bitcnt_rst_en,
  output logic scl_drive_en
);
  // A busy bus not taken by us means another master issued the START.
  assign refused       = start_req & bb_q & ~own_q;
  assign start_gen_en  = start_req & mst_q & ~refused;
  assign bitcnt_rst_en = start_gen_en;
  assign scl_drive_en  = mst_q & ~refused;
endmodule

// File: rtl/ims_mode_ctl.sv
module ims_mode_ctl
  import i2c_ms_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_wr_en,
  input  logic wr_mst,
  input  logic wr_trx,
  input  logic stop_det,
  input  logic byte_done,
  input  logic al_q,
  input  logic al_set,
  input  logic refused,
  input  logic start_gen_en,
  output logic mst_q,
  output logic trx_q,
  output logic own_q,
  output logic mst_drop
);
  logic mst_d;

  assign mst_drop = master_drop(stop_det, byte_done, al_q | al_set, refused);

  always_comb begin
    mst_d = mst_q;
    if (mst_drop)       mst_d = 1'b0;
    else if (cpu_wr_en) mst_d = wr_mst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= 1'b0;
      trx_q <= 1'b0;
      own_q <= 1'b0;
    end else begin
      mst_q <= mst_d;
      if (cpu_wr_en) trx_q <= wr_trx;
      own_q <= (own_q | start_gen_en) & mst_d & ~stop_det;
    end
  end
endmodule

// File: rtl/ims_flags.sv
module ims_flags
  import i2c_ms_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic byte_done,
  input  logic bit_smp,
  input  logic sda_drive_hi,
  input  logic sda_in,
  input  logic addr_match,
  input  logic gc_match,
  input  logic mst_q,
  input  logic irq_release,
  output logic bb_q,
  output logic al_q,
  output logic aas_q,
  output logic gc_q,
  output logic lrb_q,
  output logic irq_n_q,
  output logic al_set
);
  logic frame_edge;

  assign al_set     = arb_lost_hit(mst_q, bit_smp, sda_drive_hi, sda_in);
  assign frame_edge = start_det | stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bb_q    <= 1'b0;
      al_q    <= 1'b0;
      aas_q   <= 1'b0;
      gc_q    <= 1'b0;
      lrb_q   <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      if (stop_det)       bb_q <= 1'b0;
      else if (start_det) bb_q <= 1'b1;

      if (start_det)   al_q <= 1'b0;
      else if (al_set) al_q <= 1'b1;

      if (frame_edge)      aas_q <= 1'b0;
      else if (addr_match) aas_q <= 1'b1;

      if (frame_edge)    gc_q <= 1'b0;
      else if (gc_match) gc_q <= 1'b1;

      if (bit_smp) lrb_q <= sda_in;

      if (byte_done)        irq_n_q <= 1'b0;
      else if (irq_release) irq_n_q <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_mode_status_ctl.sv
module i2c_mode_status_ctl
  import i2c_ms_pkg::*;
#(
  parameter int REG_W = STATUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr_en,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             ev_start_det,
  input  logic             ev_stop_det,
  input  logic             ev_byte_done,
  input  logic             ev_bit_smp,
  input  logic             sda_drive_hi,
  input  logic             sda_in,
  input  logic             ev_addr_match,
  input  logic             ev_gc_match,
  input  logic             start_req,
  output logic             start_gen_en,
  output logic             bitcnt_rst_en,
  output logic             scl_drive_en,
  output logic             irq_n
);
  localparam int PAD_W = (REG_W > STATUS_W) ? REG_W - STATUS_W : 0;

  logic mst, trx, own, mst_drop;
  logic bb, al, aas, gc, lrb, al_set;
  logic refused, irq_release;
  ims_status_t status;

  assign irq_release = cpu_wr_en & cpu_wdata[POS_IRQ];

  ims_start_guard u_guard (
    .start_req    (start_req),
    .mst_q        (mst),
    .bb_q         (bb),
    .own_q        (own),
    .refused      (refused),
    .start_gen_en (start_gen_en),
    .bitcnt_rst_en(bitcnt_rst_en),
    .scl_drive_en (scl_drive_en)
  );

  ims_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_wr_en   (cpu_wr_en),
    .wr_mst      (cpu_wdata[POS_MST]),
    .wr_trx      (cpu_wdata[POS_TRX]),
    .stop_det    (ev_stop_det),
    .byte_done   (ev_byte_done),
    .al_q        (al),
    .al_set      (al_set),
    .refused     (refused),
    .start_gen_en(start_gen_en),
    .mst_q       (mst),
    .trx_q       (trx),
    .own_q       (own),
    .mst_drop    (mst_drop)
  );

  ims_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_det   (ev_start_det),
    .stop_det    (ev_stop_det),
    .byte_done   (ev_byte_done),
    .bit_smp     (ev_bit_smp),
    .sda_drive_hi(sda_drive_hi),
    .sda_in      (sda_in),
    .addr_match  (ev_addr_match),
    .gc_match    (ev_gc_match),
    .mst_q       (mst),
    .irq_release (irq_release),
    .bb_q        (bb),
    .al_q        (al),
    .aas_q       (aas),
    .gc_q        (gc),
    .lrb_q       (lrb),
    .irq_n_q     (irq_n),
    .al_set      (al_set)
  );

  always_comb begin
    status.mst   = mst;
    status.trx   = trx;
    status.bb    = bb;
    status.irq_n = irq_n;
    status.al    = al;
    status.aas   = aas;
    status.gc    = gc;
    status.lrb   = lrb;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign cpu_rdata = {{PAD_W{1'b0}}, status};
    end else begin : g_nopad
      assign cpu_rdata = status[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/i2c_mode_status_chk.sv
module i2c_mode_status_chk (
  input logic clk,
  input logic rst_n,
  input logic mst,
  input logic bb,
  input logic al,
  input logic irq_n,
  input logic al_set,
  input logic refused,
  input logic ev_start_det,
  input logic ev_stop_det,
  input logic ev_byte_done,
  input logic start_gen_en,
  input logic bitcnt_rst_en,
  input logic scl_drive_en
);
  a_r3_lost_byte_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte_done && al) |=> !mst);

  a_r4_stop_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_det |=> (!mst && !bb));

  a_r5_refusal_gates_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> (!start_gen_en && !bitcnt_rst_en && !scl_drive_en));

  a_r5_refusal_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> !mst);

  a_r6_start_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    start_gen_en |-> mst);

  a_r7_byte_end_requests_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_done |=> !irq_n);

  a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_det && !ev_stop_det) |=> bb);

  a_r9_loss_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (al_set && !ev_start_det) |=> al);

  a_r9_start_clears_loss: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_det |=> !al);

  a_r9_no_loss_as_slave: assert property (@(posedge clk) disable iff (!rst_n)
    al_set |-> mst);
endmodule

bind i2c_mode_status_ctl i2c_mode_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mst          (mst),
  .bb           (bb),
  .al           (al),
  .irq_n        (irq_n),
  .al_set       (al_set),
  .refused      (refused),
  .ev_start_det (ev_start_det),
  .ev_stop_det  (ev_stop_det),
  .ev_byte_done (ev_byte_done),
  .start_gen_en (start_gen_en),
  .bitcnt_rst_en(bitcnt_rst_en),
  .scl_drive_en (scl_drive_en)
);

// File: tb/i2c_mode_status_ctl_tb_top.sv
module i2c_mode_status_ctl_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr_en = 1'b0;
  logic [W-1:0] cpu_wdata = '0;
  logic [W-1:0] cpu_rdata;
  logic ev_start_det = 1'b0, ev_stop_det = 1'b0, ev_byte_done = 1'b0;
  logic ev_bit_smp = 1'b0, sda_drive_hi = 1'b0, sda_in = 1'b1;
  logic ev_addr_match = 1'b0, ev_gc_match = 1'b0, start_req = 1'b0;
  logic start_gen_en, bitcnt_rst_en, scl_drive_en, irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    string        req;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  i2c_mode_status_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ev_start_det(ev_start_det), .ev_stop_det(ev_stop_det),
    .ev_byte_done(ev_byte_done), .ev_bit_smp(ev_bit_smp), .sda_drive_hi(sda_drive_hi),
    .sda_in(sda_in), .ev_addr_match(ev_addr_match), .ev_gc_match(ev_gc_match),
    .start_req(start_req), .start_gen_en(start_gen_en), .bitcnt_rst_en(bitcnt_rst_en),
    .scl_drive_en(scl_drive_en), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // Packs bench-side field values into the documented bit order.
  function automatic logic [W-1:0] sbyte(input bit m, input bit t, input bit b, input bit q,
                                         input bit a, input bit s, input bit g, input bit l);
    return {m, t, b, q, a, s, g, l};
  endfunction

  task automatic idle_inputs;
    cpu_wr_en = 0; cpu_wdata = '0; ev_start_det = 0; ev_stop_det = 0;
    ev_byte_done = 0; ev_bit_smp = 0; sda_drive_hi = 0; sda_in = 1;
    ev_addr_match = 0; ev_gc_match = 0; start_req = 0;
  endtask

  // Driver: inputs are already set at the falling edge; queue the expected byte.
  task automatic tick(input logic [W-1:0] exp, input string req);
    sb_q.push_back('{exp: exp, req: req});
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  // Monitor: after each rising edge, compare the status byte to the queue head.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(cpu_rdata === it.exp, it.req, cpu_rdata, it.exp);
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0x00 expected=0x01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(cpu_rdata === 8'h10, "R1 reset byte", cpu_rdata, 8'h10);
    check({start_gen_en, bitcnt_rst_en, scl_drive_en} === 3'b000, "R1 gating idle",
          {5'b0, start_gen_en, bitcnt_rst_en, scl_drive_en}, 8'h00);

    // R2 master transmit, R11 read-only bits ignore the write
    cpu_wr_en = 1; cpu_wdata = 8'hEF;
    tick(sbyte(1,1,0,1,0,0,0,0), "R2 R11 write mode 11");

    // R6 local START on a free bus
    start_req = 1; #1;
    check({start_gen_en, bitcnt_rst_en, scl_drive_en} === 3'b111, "R6 start allowed",
          {5'b0, start_gen_en, bitcnt_rst_en, scl_drive_en}, 8'h07);
    tick(sbyte(1,1,0,1,0,0,0,0), "R6 state after start");

    ev_start_det = 1;
    tick(sbyte(1,1,1,1,0,0,0,0), "R8 start sets busy");

    ev_bit_smp = 1; sda_drive_hi = 1; sda_in = 1;
    tick(sbyte(1,1,1,1,0,0,0,1), "R10 last bit 1");

    ev_bit_smp = 1; sda_drive_hi = 1; sda_in = 0;
    tick(sbyte(1,1,1,1,1,0,0,0), "R9 arbitration lost");

    ev_byte_done = 1;
    tick(sbyte(0,1,1,0,1,0,0,0), "R3 R7 lost byte drops master, irq");

    cpu_wr_en = 1; cpu_wdata = 8'h10;
    tick(sbyte(0,0,1,1,1,0,0,0), "R7 release and R2 mode 00");

    ev_start_det = 1;
    tick(sbyte(0,0,1,1,0,0,0,0), "R9 start clears lost");

    ev_addr_match = 1; ev_gc_match = 1;
    tick(sbyte(0,0,1,1,0,1,1,0), "R10 match flags");

    ev_stop_det = 1;
    tick(sbyte(0,0,0,1,0,0,0,0), "R4 R8 R10 stop clears");

    cpu_wr_en = 1; cpu_wdata = 8'h80;
    tick(sbyte(1,0,0,1,0,0,0,0), "R2 mode 10");

    ev_start_det = 1;
    tick(sbyte(1,0,1,1,0,0,0,0), "R8 foreign start");

    // R5 refused START
    start_req = 1; #1;
    check({start_gen_en, bitcnt_rst_en, scl_drive_en} === 3'b000, "R5 refused gating",
          {5'b0, start_gen_en, bitcnt_rst_en, scl_drive_en}, 8'h00);
    tick(sbyte(0,0,1,1,0,0,0,0), "R5 refusal drops master");

    // R12 / R4: write against STOP
    cpu_wr_en = 1; cpu_wdata = 8'hC0; ev_stop_det = 1;
    tick(sbyte(0,1,0,1,0,0,0,0), "R12 R4 stop beats write, trx loads");

    // R7 byte end beats a release write; no loss so master stays
    cpu_wr_en = 1; cpu_wdata = 8'h90; ev_byte_done = 1;
    tick(sbyte(1,0,0,0,0,0,0,0), "R7 byte end wins, R2 mode 10");

    ev_start_det = 1; ev_stop_det = 1;
    tick(sbyte(0,0,0,0,0,0,0,0), "R8 stop wins over start");

    cpu_wr_en = 1; cpu_wdata = 8'h40;
    tick(sbyte(0,1,0,0,0,0,0,0), "R7 write 0 keeps irq, R2 mode 01");

    ev_bit_smp = 1; sda_drive_hi = 1; sda_in = 0;
    tick(sbyte(0,1,0,0,0,0,0,0), "R9 no loss as slave");

    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "scoreboard drained", W'(sb_q.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule